// File: doc/BRIEF.md
# Root Port Reset Sequencer

This block drives the reset of one root port of a host controller and reports how it ended. A caller pulses `start` with a port number. The block reads that port's status/control word and writes it back with the reset bit set and the enable bit cleared. It then samples the reset bit on a coarse period until the port clears it or the overall timeout runs out.

If the reset bit is still set after the last coarse sample, the block clears it itself. That write holds the write-1-to-clear change flags at zero, so no pending change is lost. The block then samples on a fine period for a bounded number of attempts. When the sequence ends, the block gives a one-cycle `done` pulse with a 2-bit outcome: success, no device, unexpected change, or still busy.

The port word comes in on `portStsIn`, which always shows the port named on `tgtPort`. Writes go out on `portWrEn`/`portWrData` and are meant for that same port. The periods, the timeout and the number of fine attempts are cycle counts set by parameters.

Top module: `port_reset_seq`

## Requirements
- R1: One cycle after `start` is taken, the block writes the port word it read, with bit 8 (reset) forced to 1 and bit 2 (enable) forced to 0. All other bits are written as read. This is the only write of a sequence that has bit 8 set.
- R2: A `start` is accepted only while `busy` is low. `tgtPort` takes `portIdx` when the start is accepted and holds it until the sequence ends. A `start` during a sequence has no effect.
- R3: Bit 8 is sampled every POLL_CYC cycles, counted from the cycle after the start write. If sample k (1-based) reads bit 8 clear, `done` rises 1 + k·POLL_CYC cycles after the start edge.
- R4: If all TIMEOUT_CYC/POLL_CYC coarse samples read bit 8 set, the next cycle writes the read word with bits 8, 1, 3 and 5 at zero and all other bits as read. Bits 1 (connect change), 3 (enable change) and 5 (over-current change) are write-1-to-clear, so this write leaves them pending.
- R5: After the forced write, bit 8 is sampled every FINE_CYC cycles for at most FINE_TRIES samples. The sequence ends at the first sample with bit 8 clear, or after the last sample.
- R6: The result is 1 (no device) when bit 0 (connect) is clear in the final sample. This takes priority over every other outcome.
- R7: The result is 2 (unexpected change) when the device is connected and bit 1 is set in the final sample.
- R8: Otherwise the result is 0 (success) when bit 8 is clear and bit 2 is set in the final sample, and 3 (busy) in every other case.
- R9: `done` is high for exactly one cycle per sequence, with `result` valid in that cycle. `busy` falls in the following cycle.
- R10: After reset, `busy`, `done` and `portWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a port reset sequence |
| portIdx | input | IDX_W | Port to reset, taken with `start` |
| tgtPort | output | IDX_W | Port the current sequence works on |
| portStsIn | input | 32 | Current status/control word of `tgtPort` |
| portWrEn | output | 1 | Write strobe for the port word |
| portWrData | output | 32 | Word to write to `tgtPort` |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| result | output | 2 | Outcome code, valid with `done` |

## Verification
The port model in the bench clears its reset bit after a chosen delay, or never. One variant also refuses the forced clear. Delays just below and exactly at the timeout separate an early coarse exit from the forced path. The latency exposes any off-by-one in the sample count.

The model can also withhold enable, drop the connection, or raise change flags during the reset. These cases tell the four outcome codes apart and check their priority order. The case that raises change flags also shows that the forced write leaves those flags pending. A second start during a running sequence shows that the target port and the write count stay unchanged.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int WORD_W = 32;
  localparam int B_CONN = 0;
  localparam int B_CONN_CHG = 1;
  localparam int B_EN = 2;
  localparam int B_EN_CHG = 3;
  localparam int B_OC_CHG = 5;
  localparam int B_RESET = 8;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_NOCONN = 2'd1,
    RES_CHANGE = 2'd2,
    RES_BUSY   = 2'd3
  } seqResult_t;

  typedef struct packed {
    logic latch;
    logic issueWr;
    logic forceWr;
    logic loadPoll;
    logic loadFine;
    logic clrCount;
    logic incCount;
    logic capture;
  } seqStrobes_t;
endpackage

// File: rtl/prs_ctrl.sv
module prs_ctrl
  import prs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        tmrZero,
  input  logic        rstSeen,
  input  logic        lastCoarse,
  input  logic        lastFine,
  output seqStrobes_t strb,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_COARSE, ST_FORCE, ST_FINE, ST_DONE
  } seqState_t;

  seqState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.latch = 1'b1;
          stateNxt = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strb.issueWr  = 1'b1;
        strb.loadPoll = 1'b1;
        strb.clrCount = 1'b1;
        stateNxt = ST_COARSE;
      end
      ST_COARSE: begin
        if (tmrZero) begin
          strb.capture = 1'b1;
          if (!rstSeen) begin
            stateNxt = ST_DONE;
          end else if (lastCoarse) begin
            stateNxt = ST_FORCE;
          end else begin
            strb.loadPoll = 1'b1;
            strb.incCount = 1'b1;
          end
        end
      end
      ST_FORCE: begin
        strb.forceWr  = 1'b1;
        strb.loadFine = 1'b1;
        strb.clrCount = 1'b1;
        stateNxt = ST_FINE;
      end
      ST_FINE: begin
        if (tmrZero) begin
          strb.capture = 1'b1;
          if (!rstSeen || lastFine) begin
            stateNxt = ST_DONE;
          end else begin
            strb.loadFine = 1'b1;
            strb.incCount = 1'b1;
          end
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/prs_datapath.sv
module prs_datapath
  import prs_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int POLL_CYC   = 2_500_000,
  parameter int NUM_POLLS  = 10,
  parameter int FINE_CYC   = 50,
  parameter int FINE_TRIES = 100_000,
  localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int TMR_MAX   = (POLL_CYC > FINE_CYC) ? POLL_CYC : FINE_CYC,
  localparam int TMR_W     = (TMR_MAX > 1) ? $clog2(TMR_MAX) : 1,
  localparam int CNT_MAX   = (NUM_POLLS > FINE_TRIES) ? NUM_POLLS : FINE_TRIES,
  localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [IDX_W-1:0]  portIdx,
  input  logic [WORD_W-1:0] portStsIn,
  output logic [IDX_W-1:0]  tgtPort,
  output logic              portWrEn,
  output logic [WORD_W-1:0] portWrData,
  output logic              tmrZero,
  output logic              rstSeen,
  output logic              lastCoarse,
  output logic              lastFine,
  output logic [1:0]        result
);
  localparam logic [WORD_W-1:0] CHG_MASK =
    (WORD_W'(1) << B_CONN_CHG) | (WORD_W'(1) << B_EN_CHG) | (WORD_W'(1) << B_OC_CHG);
  localparam logic [WORD_W-1:0] RST_MASK = WORD_W'(1) << B_RESET;
  localparam logic [WORD_W-1:0] EN_MASK  = WORD_W'(1) << B_EN;

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] sampleCnt;
  logic capConn, capConnChg, capEn, capRst;
  seqResult_t resNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (strb.loadPoll) begin
      tmr <= TMR_W'(POLL_CYC - 1);
    end else if (strb.loadFine) begin
      tmr <= TMR_W'(FINE_CYC - 1);
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              sampleCnt <= '0;
    else if (strb.clrCount) sampleCnt <= '0;
    else if (strb.incCount) sampleCnt <= sampleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           tgtPort <= '0;
    else if (strb.latch) tgtPort <= portIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {capConn, capConnChg, capEn, capRst} <= '0;
    end else if (strb.capture) begin
      capConn    <= portStsIn[B_CONN];
      capConnChg <= portStsIn[B_CONN_CHG];
      capEn      <= portStsIn[B_EN];
      capRst     <= portStsIn[B_RESET];
    end
  end

  assign tmrZero    = (tmr == '0);
  assign rstSeen    = portStsIn[B_RESET];
  assign lastCoarse = (sampleCnt == CNT_W'(NUM_POLLS - 1));
  assign lastFine   = (sampleCnt == CNT_W'(FINE_TRIES - 1));

  always_comb begin
    portWrEn   = strb.issueWr | strb.forceWr;
    portWrData = '0;
    if (strb.issueWr)      portWrData = (portStsIn | RST_MASK) & ~EN_MASK;
    else if (strb.forceWr) portWrData = portStsIn & ~(RST_MASK | CHG_MASK);
  end

  always_comb begin
    if (!capConn)              resNow = RES_NOCONN;
    else if (capConnChg)       resNow = RES_CHANGE;
    else if (!capRst && capEn) resNow = RES_OK;
    else                       resNow = RES_BUSY;
  end

  assign result = resNow;
endmodule

// File: rtl/port_reset_seq.sv
module port_reset_seq
  import prs_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int POLL_CYC    = 2_500_000,
  parameter int TIMEOUT_CYC = 25_000_000,
  parameter int FINE_CYC    = 50,
  parameter int FINE_TRIES  = 100_000,
  localparam int IDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int NUM_POLLS  = (TIMEOUT_CYC / POLL_CYC > 0) ? TIMEOUT_CYC / POLL_CYC : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  portIdx,
  output logic [IDX_W-1:0]  tgtPort,
  input  logic [31:0]       portStsIn,
  output logic              portWrEn,
  output logic [31:0]       portWrData,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result
);
  seqStrobes_t strb;
  logic tmrZero, rstSeen, lastCoarse, lastFine;

  prs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .tmrZero(tmrZero),
    .rstSeen(rstSeen), .lastCoarse(lastCoarse), .lastFine(lastFine),
    .strb(strb), .busy(busy), .done(done)
  );

  prs_datapath #(
    .NUM_PORTS(NUM_PORTS), .POLL_CYC(POLL_CYC), .NUM_POLLS(NUM_POLLS),
    .FINE_CYC(FINE_CYC), .FINE_TRIES(FINE_TRIES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .portIdx(portIdx),
    .portStsIn(portStsIn), .tgtPort(tgtPort), .portWrEn(portWrEn),
    .portWrData(portWrData), .tmrZero(tmrZero), .rstSeen(rstSeen),
    .lastCoarse(lastCoarse), .lastFine(lastFine), .result(result)
  );
endmodule

// File: rtl/port_reset_seq_chk.sv
module port_reset_seq_chk #(
  parameter int IDX_W    = 2,
  parameter int MAX_BUSY = 1000
) (
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] tgtPort,
  input logic             portWrEn,
  input logic             wrRst,
  input logic             wrEn,
  input logic [2:0]       wrChg,
  input logic             busy,
  input logic             done
);
  logic [39:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> portWrEn && wrRst && !wrEn); // R1
  AST_WRITE_IN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    portWrEn |-> busy); // R1
  AST_HOLD_PORT: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(tgtPort)); // R2
  AST_FORCE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    portWrEn && !wrRst |-> wrChg == 3'b000); // R4
  AST_BOUNDED_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= 40'(MAX_BUSY)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R9
endmodule

bind port_reset_seq port_reset_seq_chk #(
  .IDX_W(IDX_W),
  .MAX_BUSY(TIMEOUT_CYC + FINE_CYC * FINE_TRIES + 8)
) chk_i (
  .clk(clk), .rstN(rstN), .tgtPort(tgtPort), .portWrEn(portWrEn),
  .wrRst(portWrData[8]), .wrEn(portWrData[2]),
  .wrChg({portWrData[5], portWrData[3], portWrData[1]}),
  .busy(busy), .done(done)
);

// File: tb/port_reset_seq_tb_top.sv
module port_reset_seq_tb_top;
  localparam int NP = 4, POLL = 8, TMO = 80, FC = 2, FT = 16;

  typedef struct packed {
    logic [7:0] dly;
    logic       hard;
    logic       conn;
    logic       peOn;
    logic       csOn;
    logic       chg;
    logic [1:0] expRes;
    logic [7:0] expLat;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{8'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd9},
    '{8'd20, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd25},
    '{8'd79, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd81},
    '{8'd80, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd84},
    '{8'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'd84},
    '{8'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'd114},
    '{8'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'd9},
    '{8'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 8'd9},
    '{8'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 8'd9},
    '{8'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 8'd84},
    '{8'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 8'd9}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] portIdx = '0;
  logic [1:0] tgtPort;
  logic [31:0] portStsIn, portWrData;
  logic portWrEn, busy, done;
  logic [1:0] result;

  logic mdlLoad = 1'b0;
  logic [7:0] cfgDly = '0;
  logic cfgHard = 0, cfgConn = 0, cfgPeOn = 0, cfgCsOn = 0, cfgChg = 0;

  logic mConn, mCsc, mPe, mPec, mOcc, mRst, chgArm, forceSeen;
  logic [7:0] mCnt;
  logic [31:0] issueData, forceData;
  int wrCnt, doneCnt;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  port_reset_seq #(.NUM_PORTS(NP), .POLL_CYC(POLL), .TIMEOUT_CYC(TMO),
                   .FINE_CYC(FC), .FINE_TRIES(FT)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .portIdx(portIdx), .tgtPort(tgtPort),
    .portStsIn(portStsIn), .portWrEn(portWrEn), .portWrData(portWrData),
    .busy(busy), .done(done), .result(result)
  );

  // Port model: bit 12 is a constant marker that every write must keep
  assign portStsIn = {19'd0, 1'b1, 3'd0, mRst, 2'b00, mOcc, 1'b0, mPec, mPe, mCsc, mConn};

  always @(posedge clk) begin
    if (mdlLoad) begin
      mConn <= cfgConn; mCsc <= 0; mPe <= cfgConn; mPec <= 0; mOcc <= 0;
      mRst <= 0; mCnt <= 0; chgArm <= 0; forceSeen <= 0;
      issueData <= 0; forceData <= 0; wrCnt <= 0; doneCnt <= 0;
    end else begin
      if (done) doneCnt <= doneCnt + 1;
      if (mRst && mCnt == 8'd1) begin
        mRst <= 0;
        if (cfgPeOn && mConn) mPe <= 1;
        if (cfgCsOn) mCsc <= 1;
      end
      if (mCnt != 0) mCnt <= mCnt - 1;
      if (chgArm) begin
        mCsc <= 1; mPec <= 1; mOcc <= 1; chgArm <= 0;
      end
      if (portWrEn) begin
        wrCnt <= wrCnt + 1;
        if (portWrData[1]) mCsc <= 0;
        if (portWrData[3]) mPec <= 0;
        if (portWrData[5]) mOcc <= 0;
        if (!portWrData[2]) mPe <= 0;
        if (portWrData[8]) begin
          issueData <= portWrData;
          if (!mRst) begin
            mRst <= 1; mCnt <= cfgDly; chgArm <= cfgChg;
          end
        end else begin
          forceSeen <= 1; forceData <= portWrData;
          if (!cfgHard) mRst <= 0;
        end
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadModel(input vec_t v);
    @(negedge clk);
    cfgDly = v.dly; cfgHard = v.hard; cfgConn = v.conn;
    cfgPeOn = v.peOn; cfgCsOn = v.csOn; cfgChg = v.chg;
    mdlLoad = 1;
    @(negedge clk);
    mdlLoad = 0;
  endtask

  task automatic runSeq(input logic [1:0] idx, output int lat);
    @(negedge clk);
    start = 1; portIdx = idx;
    @(negedge clk);
    start = 0;
    lat = 0;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic string resReq(input logic [1:0] r);
    case (r)
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10: outputs idle during and after reset
    check(!busy && !done && !portWrEn, "R10", {busy, done, portWrEn}, 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !done && !portWrEn, "R10", {busy, done, portWrEn}, 0);

    for (int i = 0; i < 11; i++) begin
      vec_t v;
      v = VECS[i];
      loadModel(v);
      runSeq(2'(i), lat);
      check(done === 1'b1, "R9", done, 1);
      check(result == v.expRes, resReq(v.expRes), result, v.expRes);
      check(lat == int'(v.expLat), (v.expLat > 8'd81) ? "R5" : "R3", lat, v.expLat);
      check(tgtPort == 2'(i), "R2", tgtPort, 2'(i));
      check(issueData == (32'h1100 | 32'(v.conn)), "R1", issueData, 32'h1100 | 32'(v.conn));
      check(forceSeen == (v.expLat > 8'd81), "R4", forceSeen, v.expLat > 8'd81);
      if (v.expLat > 8'd81)
        check((forceData & 32'h112A) == 32'h1000, "R4", forceData, 32'h1000);
      if (v.chg)
        check(portStsIn[3] && portStsIn[5], "R4", portStsIn, 32'h28);
      @(negedge clk);
      check(!done && !busy, "R9", {done, busy}, 0);
    end

    // R2: start during a sequence is ignored
    loadModel('{8'd20, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd25});
    @(negedge clk);
    start = 1; portIdx = 2'd1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    start = 1; portIdx = 2'd2;
    @(negedge clk);
    start = 0;
    repeat (60) @(negedge clk);
    check(doneCnt == 1, "R2", doneCnt, 1);
    check(wrCnt == 1, "R2", wrCnt, 1);
    check(tgtPort == 2'd1, "R2", tgtPort, 1);
    check(result == 2'd0, "R8", result, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule